// File: doc/BRIEF.md
# Asynchronous Serial Transmit Engine with Break and Idle Queuing

This block serialises bytes (or 9-bit words) onto a single asynchronous serial line. Software or a neighbouring block places a word in a one-entry holding buffer. The engine moves that word into its shift register on a baud tick, once the shift register is free. The engine then puts one bit time on the line per baud tick: a low start bit, the data least significant bit first, then one or two high stop bits. A flag tells the writer when the holding buffer may take the next word.

The engine can also send two special characters. A break character holds the line low for a whole character time. Its length comes from three mode inputs, and it repeats for as long as the break request stays high. An idle character holds the line high for one frame time, and it is requested by turning the transmitter on. When several characters wait at once, they go to the line in a fixed priority order. Turning the transmitter off never cuts a character short. The line is released to a steady high only when the shift register empties.

The controller has five states. `ST_OFF` means disabled and empty, with the line high. `ST_READY` means enabled and empty, with the line high. `ST_DATA`, `ST_BREAK` and `ST_IDLE` each mean that a character of that kind is being shifted out. Leaving `ST_OFF` or `ST_READY`, or finishing the last bit of an active character, takes the state to the launched character's state. If nothing launches, the state goes to `ST_READY` when the transmitter is enabled and to `ST_OFF` when it is not. Active states otherwise hold until the baud tick that ends their last bit.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset `buf_empty` is 1, `serial_out` is 1, and no break or idle request is pending.
- R2: A data frame is one 0 bit, then data LSB first, then stop bits of value 1. The data is `wr_data[7:0]` when `nine_bit`=0, or `wr_data[8:0]` when `nine_bit`=1. There is one stop bit when `two_stop`=0 and two when `two_stop`=1. A character launches on the baud tick on which the shift register is free, and that tick's edge puts its first bit on the line. Each later tick advances one bit.
- R3: A write clears `buf_empty` on the next clock edge. `buf_empty` returns to 1 on the baud-tick edge that moves the buffered word into the shift register.
- R4: A 0-to-1 change of `brk_req` queues a break character. While the break is shifted, `serial_out` is 0 for every bit time, including the stop positions.
- R5: The break length in bit times is 10 + `nine_bit` + `two_stop` + 3·`brk_ext`. This gives 10 to 15.
- R6: If `brk_req` is still 1 on the tick that launches a break, another break is queued. Breaks therefore follow back to back until `brk_req` falls. The break already queued at that point is still sent.
- R7: A 0-to-1 change of `tx_en` queues an idle character. The line is held 1 for 10 + `nine_bit` + `two_stop` bit times, and a buffered word is launched only after it.
- R8: When the shift register frees, a queued break launches first, then a queued idle, then buffered data.
- R9: Dropping `tx_en` during a character lets it finish unchanged. While `tx_en` is 0 and the shift register is empty, `serial_out` is 1, nothing launches, and a written word stays buffered (`buf_empty` stays 0).
- R10: `serial_out` changes only on a clock edge at which `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Writes `wr_data` into the holding buffer |
| wr_data | input | 9 | Word to send; bit 8 is used only in 9-bit mode |
| tx_en | input | 1 | Transmitter enable; a rising change queues an idle character |
| brk_req | input | 1 | Break request; a rising change queues a break, and holding it repeats breaks |
| brk_ext | input | 1 | Lengthens breaks by three bit times |
| nine_bit | input | 1 | Selects 9 data bits instead of 8 |
| two_stop | input | 1 | Selects two stop bits instead of one |
| buf_empty | output | 1 | Holding buffer may be written |
| serial_out | output | 1 | Serial line, high when idle |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse, and that `wr_en` is not asserted in the same cycle as a baud tick that launches data. The mode inputs are assumed to stay steady while a character is being launched. The stimulus meets these assumptions in three ways. It drives every input on the falling clock edge. It raises the tick for one cycle in every other cycle. It changes the mode inputs and writes the buffer only in cycles without a tick, while the engine is in `ST_READY` or `ST_OFF`.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_OFF,
        ST_READY,
        ST_DATA,
        ST_BREAK,
        ST_IDLE
    } tx_state_e;

    // What the shift register is loaded with on a launch tick
    typedef enum logic [1:0] {
        LD_NONE,
        LD_BREAK,
        LD_IDLE,
        LD_DATA
    } load_kind_e;

endpackage

// File: rtl/tx_request_queue.sv
module tx_request_queue
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              brk_req,
    input  load_kind_e        load_kind,
    output logic              brk_pend,
    output logic              idle_pend,
    output logic              buf_full,
    output logic [DATA_W-1:0] buf_word
);

    logic en_q;
    logic brk_q;
    logic en_rise;
    logic brk_rise;

    assign en_rise  = tx_en & ~en_q;
    assign brk_rise = brk_req & ~brk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            brk_q     <= 1'b0;
            brk_pend  <= 1'b0;
            idle_pend <= 1'b0;
            buf_full  <= 1'b0;
            buf_word  <= '0;
        end else begin
            en_q  <= tx_en;
            brk_q <= brk_req;

            // A launched break re-arms itself while the request is held
            if (load_kind == LD_BREAK) begin
                brk_pend <= brk_req;
            end else if (brk_rise) begin
                brk_pend <= 1'b1;
            end

            if (en_rise) begin
                idle_pend <= 1'b1;
            end else if (load_kind == LD_IDLE) begin
                idle_pend <= 1'b0;
            end

            // A write wins over a simultaneous hand-over to the shifter
            if (wr_en) begin
                buf_full <= 1'b1;
                buf_word <= wr_data;
            end else if (load_kind == LD_DATA) begin
                buf_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tx_bit_shifter.sv
module tx_bit_shifter #(
    parameter int SR_W  = 12,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             load,
    input  logic [SR_W-1:0]  load_bits,
    input  logic [CNT_W-1:0] load_len,
    output logic             last_bit,
    output logic             head_bit
);

    logic [SR_W-1:0]  sreg;
    logic [CNT_W-1:0] remain;

    assign last_bit = (remain == CNT_W'(1));
    assign head_bit = sreg[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg   <= '1;
            remain <= '0;
        end else if (load) begin
            sreg   <= load_bits;
            remain <= load_len;
        end else if (baud_tick && (remain != '0)) begin
            sreg   <= {1'b1, sreg[SR_W-1:1]};
            remain <= remain - CNT_W'(1);
        end
    end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int BRK_EXTRA = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              brk_ext,
    input  logic              nine_bit,
    input  logic              two_stop,
    output logic              buf_empty,
    output logic              serial_out
);

    localparam int SR_W    = DATA_W + 3;
    localparam int LEN_MAX = SR_W + BRK_EXTRA;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    tx_state_e         state;
    tx_state_e         state_nx;
    load_kind_e        load_kind;
    logic              brk_pend;
    logic              idle_pend;
    logic              buf_full;
    logic [DATA_W-1:0] buf_word;
    logic              sh_last;
    logic              sh_head;
    logic              sh_free;
    logic [SR_W-1:0]   frame_bits;
    logic [CNT_W-1:0]  frame_len;
    logic [CNT_W-1:0]  load_len;

    tx_request_queue #(
        .DATA_W (DATA_W)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .load_kind (load_kind),
        .brk_pend  (brk_pend),
        .idle_pend (idle_pend),
        .buf_full  (buf_full),
        .buf_word  (buf_word)
    );

    tx_bit_shifter #(
        .SR_W  (SR_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .load      (load_kind != LD_NONE),
        .load_bits (frame_bits),
        .load_len  (load_len),
        .last_bit  (sh_last),
        .head_bit  (sh_head)
    );

    // Frame length in bit times: start + data + stop
    always_comb begin
        frame_len = CNT_W'(1 + (nine_bit ? DATA_W : DATA_W - 1) + (two_stop ? 2 : 1));
    end

    // Data frame image, LSB shifted out first; unused upper positions are stop level
    always_comb begin
        frame_bits    = '1;
        frame_bits[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (nine_bit || (i < DATA_W - 1)) begin
                frame_bits[1 + i] = buf_word[i];
            end
        end
    end

    // Shift register can accept a new character on this cycle
    always_comb begin
        sh_free = (state == ST_OFF) || (state == ST_READY) || (baud_tick && sh_last);
    end

    // Launch selection with fixed priority
    always_comb begin
        load_kind = LD_NONE;
        load_len  = frame_len;
        if (baud_tick && tx_en && sh_free) begin
            if (brk_pend) begin
                load_kind = LD_BREAK;
                load_len  = frame_len + (brk_ext ? CNT_W'(BRK_EXTRA) : CNT_W'(0));
            end else if (idle_pend) begin
                load_kind = LD_IDLE;
            end else if (buf_full) begin
                load_kind = LD_DATA;
            end
        end
    end

    function automatic tx_state_e after_launch(load_kind_e k, logic en);
        tx_state_e s;
        unique case (k)
            LD_BREAK: s = ST_BREAK;
            LD_IDLE:  s = ST_IDLE;
            LD_DATA:  s = ST_DATA;
            default:  s = en ? ST_READY : ST_OFF;
        endcase
        return s;
    endfunction

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF, ST_READY: begin
                state_nx = after_launch(load_kind, tx_en);
            end
            ST_DATA, ST_BREAK, ST_IDLE: begin
                if (baud_tick && sh_last) begin
                    state_nx = after_launch(load_kind, tx_en);
                end
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    // Outputs
    always_comb begin
        buf_empty = ~buf_full;
        unique case (state)
            ST_DATA:  serial_out = sh_head;
            ST_BREAK: serial_out = 1'b0;
            default:  serial_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker
    import uart_tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      baud_tick,
    input logic      wr_en,
    input logic      tx_en,
    input logic      buf_empty,
    input logic      serial_out,
    input tx_state_e state
);

    p_off_line_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> serial_out);

    p_off_stays_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !tx_en) |=> (state == ST_OFF || state == ST_READY));

    p_break_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK) |-> !serial_out);

    p_write_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    p_empty_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(baud_tick));

    p_tick_paced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(serial_out));

endmodule

bind uart_tx_engine uart_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .tx_en      (tx_en),
    .buf_empty  (buf_empty),
    .serial_out (serial_out),
    .state      (state)
);

// File: tb/sim_uart_tx_engine.sv
`timescale 1ns/1ps
module sim_uart_tx_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       brk_ext = 1'b0;
    logic       nine_bit = 1'b0;
    logic       two_stop = 1'b0;
    logic       buf_empty;
    logic       serial_out;

    int checks = 0;
    int fails  = 0;
    logic cap [64];

    always #4 clk = ~clk;

    uart_tx_engine u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_en      (tx_en),
        .brk_req    (brk_req),
        .brk_ext    (brk_ext),
        .nine_bit   (nine_bit),
        .two_stop   (two_stop),
        .buf_empty  (buf_empty),
        .serial_out (serial_out)
    );

    typedef struct packed {
        logic [8:0] d;
        logic       m;
        logic       s;
        logic [3:0] len;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{9'h0A5, 1'b0, 1'b0, 4'd10},
        '{9'h001, 1'b0, 1'b1, 4'd11},
        '{9'h180, 1'b0, 1'b0, 4'd10},
        '{9'h1C3, 1'b1, 1'b0, 4'd11},
        '{9'h0FE, 1'b1, 1'b1, 4'd12},
        '{9'h133, 1'b1, 1'b0, 4'd11}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic pulse_tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic write_word(input logic [8:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic capture(input int start, input int n);
        for (int k = 0; k < n; k++) begin
            pulse_tick();
            cap[start + k] = serial_out;
        end
    endtask

    function automatic int run_len(input int start, input logic lvl);
        int n = 0;
        for (int k = start; k < 64; k++) begin
            if (cap[k] !== lvl) break;
            n++;
        end
        return n;
    endfunction

    function automatic logic exp_bit(input logic [8:0] d, input logic m, input int k);
        int nb = m ? 9 : 8;
        if (k == 0) return 1'b0;
        if (k <= nb) return d[k-1];
        return 1'b1;
    endfunction

    task automatic drain(input int n);
        for (int k = 0; k < n; k++) pulse_tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 buf_empty after reset", int'(buf_empty), 1);
        chk("R1 line after reset", int'(serial_out), 1);

        // R9 disabled: word stays buffered, line high
        write_word(9'h055);
        capture(0, 5);
        chk("R9 line high while disabled", run_len(0, 1'b1), 5);
        chk("R9 word not launched while disabled", int'(buf_empty), 0);

        // R7 and R8: enable queues idle, idle goes ahead of buffered data
        @(negedge clk) tx_en = 1'b1;
        capture(0, 12);
        chk("R7 idle length 8N1", run_len(0, 1'b1), 10);
        chk("R8 data after idle", int'(cap[10]), 0);
        chk("R3 buffer freed on launch", int'(buf_empty), 1);
        drain(12);

        // R7 idle length with 9 data bits and 2 stop bits
        nine_bit = 1'b1; two_stop = 1'b1;
        write_word(9'h100);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
        capture(0, 14);
        chk("R7 idle length 9N2", run_len(0, 1'b1), 12);
        chk("R8 start bit after idle", int'(cap[12]), 0);
        drain(14);

        // R2 and R3: table of data frames
        foreach (VEC[i]) begin
            int got = 0;
            int exp = 0;
            nine_bit = VEC[i].m;
            two_stop = VEC[i].s;
            write_word(VEC[i].d);
            chk("R3 write clears buf_empty", int'(buf_empty), 0);
            for (int k = 0; k < int'(VEC[i].len); k++) begin
                pulse_tick();
                got |= int'(serial_out) << k;
                exp |= int'(exp_bit(VEC[i].d, VEC[i].m, k)) << k;
                if (k == 0) chk("R3 buf_empty set at launch", int'(buf_empty), 1);
                if (i == 0 && k == 2) begin
                    logic held = serial_out;
                    repeat (3) @(negedge clk);
                    chk("R10 line steady without tick", int'(serial_out), int'(held));
                end
            end
            chk("R2 frame bits", got, exp);
            pulse_tick();
            chk("R2 line high after frame", int'(serial_out), 1);
        end

        // R4 and R5: break length over all mode combinations
        for (int c = 0; c < 8; c++) begin
            int blen;
            brk_ext  = c[2];
            nine_bit = c[1];
            two_stop = c[0];
            blen = 10 + int'(c[1]) + int'(c[0]) + 3 * int'(c[2]);
            @(negedge clk) brk_req = 1'b1;
            @(negedge clk) brk_req = 1'b0;
            capture(0, 20);
            chk($sformatf("R5 break length mode %0d", c), run_len(0, 1'b0), blen);
            chk("R4 line high after break", int'(cap[blen]), 1);
        end
        brk_ext = 1'b0; nine_bit = 1'b0; two_stop = 1'b0;

        // R6: held request sends a second break
        @(negedge clk) brk_req = 1'b1;
        capture(0, 5);
        brk_req = 1'b0;
        capture(5, 30);
        chk("R6 held break repeats", run_len(0, 1'b0), 20);

        // R8: break, then idle, then data
        write_word(9'h0F0);
        @(negedge clk) brk_req = 1'b1;
        @(negedge clk) begin brk_req = 1'b0; tx_en = 1'b0; end
        @(negedge clk) tx_en = 1'b1;
        capture(0, 24);
        chk("R8 break first", run_len(0, 1'b0), 10);
        chk("R8 idle second", run_len(10, 1'b1), 10);
        chk("R8 data last", int'(cap[20]), 0);
        drain(12);

        // R9: dropping enable mid-frame lets the frame finish
        begin
            int got = 0;
            int exp = 0;
            write_word(9'h03C);
            for (int k = 0; k < 10; k++) begin
                pulse_tick();
                if (k == 2) tx_en = 1'b0;
                got |= int'(serial_out) << k;
                exp |= int'(exp_bit(9'h03C, 1'b0, k)) << k;
            end
            chk("R9 frame completes after disable", got, exp);
        end
        write_word(9'h0AA);
        capture(0, 4);
        chk("R9 line high when disabled", run_len(0, 1'b1), 4);
        chk("R9 no launch when disabled", int'(buf_empty), 0);

        report();
        $finish;
    end

endmodule